// File: doc/BRIEF.md
# Mixed Page Size Translation Cache

This block caches completed virtual-to-physical translations for three mapping sizes: 4 KiB, 64 KiB and 1 MiB. It is a set-associative array of 64 sets by 8 ways. Every entry is placed in, and looked up in, the set chosen by virtual address bits [17:12], whatever its size. A 1 MiB mapping can therefore occupy any of the 64 sets, and a 64 KiB mapping any of 16 neighbouring sets. A lookup is answered one cycle after it is issued. The answer is a hit with the physical address, a miss (so a table walker can be started), or a fault when more than one way matches. A multi-hit fault is reported on a separate output for reads and for writes.

The walker loads translations through the refill port. A refill carries a virtual page number, a size code and a physical page number. Two kinds of invalidation exist. A flush-all strobe empties the array. A per-entry command word clears matching entries, but only within the one set that the address in the word selects. Inside a set, invalid ways are filled first. When the set is full, the victim is either the least recently used way or the next way in round-robin order, as selected by an input.

Top module: `mixed_page_tlb`

## Requirements
- R1: For each cycle with `lk_req` high, the next cycle has `rsp_valid` high with exactly one of `rsp_hit`, `rsp_miss` or a multi-hit fault. With no request, all response outputs are low in the next cycle.
- R2: A 4 KiB entry (size code 0) matches when virtual address bits [31:12] are equal. It returns physical address {ppn[19:0], va[11:0]}. Placement and lookup both use set index va[17:12].
- R3: A 64 KiB entry (size code 1) matches on va[31:16] and returns {ppn[19:4], va[15:0]}. A 1 MiB entry (size code 2) matches on va[31:20] and returns {ppn[19:8], va[19:0]}. Both are searched only in set va[17:12] of the lookup address.
- R4: A refill with size code 3 stores nothing.
- R5: A one-cycle `flush_all` strobe invalidates every entry. A lookup issued in the next cycle misses.
- R6: An invalidation word acts only when bit 0 is 1. It uses bits [31:12] as the address. In set word[17:12] it clears every valid entry that matches that address under the entry's own size. Entries in other sets are not affected, and a word with bit 0 clear has no effect.
- R7: When two or more ways match a lookup, there is no hit and no miss. The fault appears on `rsp_mh_wr` if `lk_write` was high with the request, and on `rsp_mh_rd` otherwise.
- R8: A refill into a set that has an invalid way uses the lowest-numbered invalid way. No valid entry is evicted.
- R9: With `lru_en` high, a refill into a full set evicts the way least recently filled or hit by a single-way lookup.
- R10: With `lru_en` low, a refill into a full set evicts the way named by a per-set pointer. The pointer starts at way 0 and advances by one after each such eviction.
- R11: A refill is dropped when `flush_all` is high in the same cycle, or when a valid invalidation word targets the same set in the same cycle. A refill to a different set than the invalidation still completes.
- R12: After reset, the array is empty and all response outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lru_en | input | 1 | 1 selects LRU replacement, 0 selects round-robin |
| lk_req | input | 1 | Lookup request |
| lk_va | input | 32 | Lookup virtual address |
| lk_write | input | 1 | Lookup is for a write access |
| fill_req | input | 1 | Refill strobe |
| fill_vpn | input | 20 | Refill virtual address bits [31:12] |
| fill_size | input | 2 | 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB, 3 = reserved |
| fill_ppn | input | 20 | Refill physical page number |
| flush_all | input | 1 | Invalidate all entries |
| inv_req | input | 1 | Invalidation word strobe |
| inv_word | input | 32 | Bits [31:12] address, bit 0 valid flag |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Single-way hit |
| rsp_miss | output | 1 | No way matched |
| rsp_mh_rd | output | 1 | Multi-hit fault on a read lookup |
| rsp_mh_wr | output | 1 | Multi-hit fault on a write lookup |
| rsp_pa | output | 32 | Physical address on a hit, zero otherwise |

## Verification
A lookup answer is registered once, so it is valid in the cycle after the request. The bench drives each request on a falling edge and reads the answer on the next falling edge, half a cycle after the capturing edge. Refills, flush-all strobes and invalidation words change the array at the rising edge that ends their cycle. A lookup issued in any later cycle sees the change, so every check of a fill, eviction or invalidation uses a lookup that starts after the strobe has been removed. The collision cases drive a refill and a flush in the same cycle, then probe with a later lookup.

// File: rtl/mpt_pkg.sv
package mpt_pkg;

    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 12;
    localparam int VPN_W    = VA_W - PG_SHIFT;
    localparam int PPN_W    = 20;

    typedef enum logic [1:0] {
        SZ_4K   = 2'd0,
        SZ_64K  = 2'd1,
        SZ_1M   = 2'd2,
        SZ_RSVD = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic             valid;
        pg_size_e         size;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;

    // Page-number bits that take part in a tag compare, per mapping size
    function automatic logic [VPN_W-1:0] vpn_mask(pg_size_e s);
        case (s)
            SZ_64K:  return {{(VPN_W-4){1'b1}}, 4'h0};
            SZ_1M:   return {{(VPN_W-8){1'b1}}, 8'h00};
            default: return {VPN_W{1'b1}};
        endcase
    endfunction

    function automatic logic [VA_W-1:0] xlate(tlb_ent_t e, logic [VA_W-1:0] va);
        case (e.size)
            SZ_64K:  return {e.ppn[PPN_W-1:4], va[15:0]};
            SZ_1M:   return {e.ppn[PPN_W-1:8], va[19:0]};
            default: return {e.ppn, va[PG_SHIFT-1:0]};
        endcase
    endfunction

endpackage

// File: rtl/mpt_way_cmp.sv
module mpt_way_cmp
    import mpt_pkg::*;
(
    input  tlb_ent_t         ent,
    input  logic [VPN_W-1:0] vpn,
    output logic             hit
);
    always_comb begin
        hit = ent.valid && (((ent.vpn ^ vpn) & vpn_mask(ent.size)) == '0);
    end
endmodule

// File: rtl/mpt_victim.sv
module mpt_victim #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid,
    input  logic [WAYS-1:0][WAY_W-1:0] age,
    input  logic [WAY_W-1:0]           rr_ptr,
    input  logic                       lru_en,
    output logic [WAY_W-1:0]           victim,
    output logic                       full
);
    logic found;

    always_comb begin
        full   = &valid;
        victim = rr_ptr;
        found  = 1'b0;
        if (!full) begin
            for (int w = 0; w < WAYS; w++) begin
                if (!valid[w] && !found) begin
                    victim = WAY_W'(w);
                    found  = 1'b1;
                end
            end
        end else if (lru_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age[w] == WAY_W'(WAYS - 1)) begin
                    victim = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/mpt_age_upd.sv
module mpt_age_upd #(
    parameter int WAYS  = 8,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_in,
    input  logic [WAY_W-1:0]           touch,
    output logic [WAYS-1:0][WAY_W-1:0] age_out
);
    // Ages form a permutation of 0..WAYS-1; the touched way becomes 0
    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (WAY_W'(w) == touch) begin
                age_out[w] = '0;
            end else if (age_in[w] < age_in[touch]) begin
                age_out[w] = age_in[w] + 1'b1;
            end else begin
                age_out[w] = age_in[w];
            end
        end
    end
endmodule

// File: rtl/mixed_page_tlb.sv
module mixed_page_tlb
    import mpt_pkg::*;
#(
    parameter int SETS = 64,
    parameter int WAYS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lru_en,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_write,
    input  logic             fill_req,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [1:0]       fill_size,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             flush_all,
    input  logic             inv_req,
    input  logic [VA_W-1:0]  inv_word,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_mh_rd,
    output logic             rsp_mh_wr,
    output logic [VA_W-1:0]  rsp_pa
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int CNT_W = $clog2(WAYS + 1);

    tlb_ent_t                   ent_q [SETS][WAYS];
    logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
    logic [WAY_W-1:0]           ptr_q [SETS];

    // ---------------- lookup side ----------------
    logic [IDX_W-1:0]  lk_set;
    logic [VPN_W-1:0]  lk_vpn;
    logic [WAYS-1:0]   lk_match;
    logic [WAY_W-1:0]  lk_way;
    logic [CNT_W-1:0]  lk_cnt;
    logic [VA_W-1:0]   lk_pa;
    logic [WAYS-1:0][WAY_W-1:0] lk_age_new;

    assign lk_set = lk_va[PG_SHIFT +: IDX_W];
    assign lk_vpn = lk_va[VA_W-1:PG_SHIFT];

    // ---------------- invalidation side ----------------
    logic             inv_go;
    logic [IDX_W-1:0] inv_set;
    logic [VPN_W-1:0] inv_vpn;
    logic [WAYS-1:0]  inv_match;
    logic             unused_inv_bits;

    assign inv_go          = inv_req && inv_word[0];
    assign inv_set         = inv_word[PG_SHIFT +: IDX_W];
    assign inv_vpn         = inv_word[VA_W-1:PG_SHIFT];
    assign unused_inv_bits = ^inv_word[PG_SHIFT-1:1];

    // ---------------- refill side ----------------
    logic [IDX_W-1:0] fill_set;
    logic [WAYS-1:0]  fill_valid;
    logic [WAY_W-1:0] fill_way;
    logic             fill_full;
    logic             fill_go;
    tlb_ent_t         fill_ent;
    logic [WAYS-1:0][WAY_W-1:0] fill_age_new;

    assign fill_set = fill_vpn[0 +: IDX_W];
    assign fill_go  = fill_req && (fill_size != SZ_RSVD) && !flush_all
                      && !(inv_go && (inv_set == fill_set));

    always_comb begin
        fill_ent.valid = 1'b1;
        fill_ent.size  = pg_size_e'(fill_size);
        fill_ent.vpn   = fill_vpn;
        fill_ent.ppn   = fill_ppn;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        mpt_way_cmp u_lk_cmp (
            .ent (ent_q[lk_set][w]),
            .vpn (lk_vpn),
            .hit (lk_match[w])
        );
        mpt_way_cmp u_inv_cmp (
            .ent (ent_q[inv_set][w]),
            .vpn (inv_vpn),
            .hit (inv_match[w])
        );
        assign fill_valid[w] = ent_q[fill_set][w].valid;
    end

    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) lk_way = WAY_W'(w);
        end
        lk_cnt = CNT_W'($countones(lk_match));
        lk_pa  = xlate(ent_q[lk_set][lk_way], lk_va);
    end

    mpt_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
        .valid  (fill_valid),
        .age    (age_q[fill_set]),
        .rr_ptr (ptr_q[fill_set]),
        .lru_en (lru_en),
        .victim (fill_way),
        .full   (fill_full)
    );

    mpt_age_upd #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age_lk (
        .age_in  (age_q[lk_set]),
        .touch   (lk_way),
        .age_out (lk_age_new)
    );

    mpt_age_upd #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age_fill (
        .age_in  (age_q[fill_set]),
        .touch   (fill_way),
        .age_out (fill_age_new)
    );

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ent_q[s][w]  <= '0;
                    age_q[s][w]  <= WAY_W'(w);
                end
                ptr_q[s] <= '0;
            end
        end else begin
            if (lk_req && (lk_cnt == CNT_W'(1)) && !(fill_go && (fill_set == lk_set))) begin
                age_q[lk_set] <= lk_age_new;
            end
            if (flush_all) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        ent_q[s][w].valid <= 1'b0;
                    end
                end
            end else if (inv_go) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (inv_match[w]) ent_q[inv_set][w].valid <= 1'b0;
                end
            end
            if (fill_go) begin
                ent_q[fill_set][fill_way] <= fill_ent;
                age_q[fill_set]           <= fill_age_new;
                if (fill_full && !lru_en) ptr_q[fill_set] <= ptr_q[fill_set] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_mh_rd <= 1'b0;
            rsp_mh_wr <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && (lk_cnt == CNT_W'(1));
            rsp_miss  <= lk_req && (lk_cnt == '0);
            rsp_mh_rd <= lk_req && (lk_cnt > CNT_W'(1)) && !lk_write;
            rsp_mh_wr <= lk_req && (lk_cnt > CNT_W'(1)) && lk_write;
            rsp_pa    <= (lk_req && (lk_cnt == CNT_W'(1))) ? lk_pa : '0;
        end
    end

endmodule

// File: rtl/mpt_checker.sv
module mpt_checker (
    input logic        clk,
    input logic        rst,
    input logic        lk_req,
    input logic        lk_write,
    input logic [11:0] lk_off,
    input logic        flush_all,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic        rsp_miss,
    input logic        rsp_mh_rd,
    input logic        rsp_mh_wr,
    input logic [11:0] rsp_off
);
    p_rsp_timing_r1: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid)
        else $error("answer missing after request");

    p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_mh_rd && !rsp_mh_wr)
        else $error("answer without request");

    p_one_outcome_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_mh_rd, rsp_mh_wr}) == 1)
        else $error("answer is not exactly one outcome");

    p_pa_offset_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_off == $past(lk_off))
        else $error("page offset not carried through");

    p_flush_empty_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_req && $past(flush_all)) |=> !rsp_hit && !rsp_mh_rd && !rsp_mh_wr)
        else $error("match found after flush-all");

    p_mh_dir_wr_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_mh_wr |-> $past(lk_write))
        else $error("write fault on read lookup");

    p_mh_dir_rd_r7: assert property (@(posedge clk) disable iff (rst)
        rsp_mh_rd |-> !$past(lk_write))
        else $error("read fault on write lookup");
endmodule

bind mixed_page_tlb mpt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .lk_req    (lk_req),
    .lk_write  (lk_write),
    .lk_off    (lk_va[11:0]),
    .flush_all (flush_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_mh_rd (rsp_mh_rd),
    .rsp_mh_wr (rsp_mh_wr),
    .rsp_off   (rsp_pa[11:0])
);

// File: tb/test_mixed_page_tlb.sv
module test_mixed_page_tlb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lru_en = 1'b1;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_write = 1'b0;
    logic        fill_req = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [1:0]  fill_size = '0;
    logic [19:0] fill_ppn = '0;
    logic        flush_all = 1'b0;
    logic        inv_req = 1'b0;
    logic [31:0] inv_word = '0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_mh_rd, rsp_mh_wr;
    logic [31:0] rsp_pa;

    int n_tests = 0;
    int n_fail  = 0;

    localparam int K_MISS = 0, K_HIT = 1, K_MH = 2;

    always #2.5 clk = ~clk;

    mixed_page_tlb i_mixed_page_tlb (
        .clk(clk), .rst(rst), .lru_en(lru_en),
        .lk_req(lk_req), .lk_va(lk_va), .lk_write(lk_write),
        .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_size(fill_size), .fill_ppn(fill_ppn),
        .flush_all(flush_all), .inv_req(inv_req), .inv_word(inv_word),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_mh_rd(rsp_mh_rd), .rsp_mh_wr(rsp_mh_wr), .rsp_pa(rsp_pa)
    );

    task automatic check(input string req, input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one cycle of any mix of refill / invalidation / flush-all
    task automatic drive(input bit f, input logic [31:0] va, input logic [1:0] sz,
                         input logic [19:0] ppn, input bit iv, input logic [31:0] word,
                         input bit fa);
        @(negedge clk);
        fill_req = f; fill_vpn = va[31:12]; fill_size = sz; fill_ppn = ppn;
        inv_req = iv; inv_word = word; flush_all = fa;
        @(negedge clk);
        fill_req = 1'b0; inv_req = 1'b0; flush_all = 1'b0;
    endtask

    task automatic fill(input logic [31:0] va, input logic [1:0] sz, input logic [19:0] ppn);
        drive(1'b1, va, sz, ppn, 1'b0, '0, 1'b0);
    endtask

    task automatic inval(input logic [31:0] word);
        drive(1'b0, '0, 2'd0, '0, 1'b1, word, 1'b0);
    endtask

    task automatic flush();
        drive(1'b0, '0, 2'd0, '0, 1'b0, '0, 1'b1);
    endtask

    // lookup; answer sampled on the falling edge after the capturing edge
    task automatic expect_lk(input string req, input logic [31:0] va, input bit wr,
                             input int kind, input logic [31:0] pa);
        logic [4:0] got, exp;
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_write = wr;
        @(negedge clk);
        lk_req = 1'b0;
        got = {rsp_valid, rsp_hit, rsp_miss, rsp_mh_rd, rsp_mh_wr};
        exp = {1'b1, kind == K_HIT, kind == K_MISS, kind == K_MH && !wr, kind == K_MH && wr};
        check(req, got == exp, $sformatf("outcome {v,h,m,mr,mw} va=%h", va),
              32'(got), 32'(exp));
        if (kind == K_HIT) check(req, rsp_pa == pa, $sformatf("pa va=%h", va), rsp_pa, pa);
    endtask

    task automatic t_reset();
        check("R12", {rsp_valid, rsp_hit, rsp_miss, rsp_mh_rd, rsp_mh_wr} == '0,
              "outputs in reset", 32'(rsp_valid), 32'h0);
        @(negedge clk); rst = 1'b0;
        expect_lk("R12", 32'h0000_1000, 1'b0, K_MISS, '0);
        expect_lk("R1", 32'h8765_4321, 1'b1, K_MISS, '0);
        @(negedge clk);
        check("R1", !rsp_valid, "valid with no request", 32'(rsp_valid), 32'h0);
    endtask

    task automatic t_small();
        fill(32'h1234_6000, 2'd0, 20'hABCDE);
        expect_lk("R2", 32'h1234_6ABC, 1'b0, K_HIT, 32'hABCD_EABC);
        expect_lk("R2", 32'h1234_6010, 1'b1, K_HIT, 32'hABCD_E010);
        expect_lk("R2", 32'h1234_7ABC, 1'b0, K_MISS, '0);
        expect_lk("R2", 32'h1274_6000, 1'b0, K_MISS, '0);
    endtask

    task automatic t_large();
        fill(32'h4003_8000, 2'd1, 20'h5555F);
        expect_lk("R3", 32'h4003_8123, 1'b0, K_HIT, 32'h5555_8123);
        expect_lk("R3", 32'h4003_9123, 1'b0, K_MISS, '0);
        expect_lk("R3", 32'h4007_8123, 1'b0, K_MISS, '0);
        fill(32'h7010_9000, 2'd2, 20'h321FF);
        expect_lk("R3", 32'h701C_9456, 1'b0, K_HIT, 32'h321C_9456);
        expect_lk("R3", 32'h7020_9000, 1'b0, K_MISS, '0);
    endtask

    task automatic t_badsize();
        fill(32'h2000_A000, 2'd3, 20'h00777);
        expect_lk("R4", 32'h2000_A000, 1'b0, K_MISS, '0);
    endtask

    task automatic t_multi();
        flush();
        fill(32'h3000_B000, 2'd0, 20'h00001);
        fill(32'h3000_B000, 2'd0, 20'h00002);
        expect_lk("R7", 32'h3000_B000, 1'b0, K_MH, '0);
        expect_lk("R7", 32'h3000_B000, 1'b1, K_MH, '0);
    endtask

    task automatic t_inval();
        flush();
        fill(32'h5000_C000, 2'd0, 20'h00A00);
        fill(32'h5004_C000, 2'd0, 20'h00B00);
        fill(32'h5000_D000, 2'd0, 20'h00C00);
        fill(32'h6000_E000, 2'd2, 20'h00D00);
        inval(32'h5000_C000);
        expect_lk("R6", 32'h5000_C000, 1'b0, K_HIT, 32'h00A0_0000);
        inval(32'h5000_C001);
        expect_lk("R6", 32'h5000_C000, 1'b0, K_MISS, '0);
        expect_lk("R6", 32'h5004_C004, 1'b0, K_HIT, 32'h00B0_0004);
        expect_lk("R6", 32'h5000_D008, 1'b0, K_HIT, 32'h00C0_0008);
        inval(32'h6004_E001);
        expect_lk("R6", 32'h6000_E000, 1'b0, K_MISS, '0);
    endtask

    task automatic t_flushall();
        fill(32'h0A00_1000, 2'd0, 20'h00011);
        fill(32'h0B00_2000, 2'd2, 20'h02200);
        expect_lk("R5", 32'h0A00_1000, 1'b0, K_HIT, 32'h0001_1000);
        flush();
        expect_lk("R5", 32'h0A00_1000, 1'b0, K_MISS, '0);
        expect_lk("R5", 32'h0B00_2000, 1'b0, K_MISS, '0);
    endtask

    function automatic logic [31:0] pg(input int k, input int set);
        return (32'(k + 1) << 18) | (32'(set) << 12);
    endfunction

    task automatic t_lru();
        flush();
        lru_en = 1'b1;
        for (int k = 0; k < 8; k++) fill(pg(k, 3), 2'd0, 20'(16'h100 + k));
        expect_lk("R9", pg(0, 3), 1'b0, K_HIT, {20'h00100, 12'h0});
        fill(pg(8, 3), 2'd0, 20'h00108);
        expect_lk("R9", pg(1, 3), 1'b0, K_MISS, '0);
        expect_lk("R9", pg(8, 3), 1'b0, K_HIT, {20'h00108, 12'h0});
        expect_lk("R9", pg(0, 3), 1'b0, K_HIT, {20'h00100, 12'h0});
        inval(pg(4, 3) | 32'h1);
        fill(pg(9, 3), 2'd0, 20'h00109);
        expect_lk("R8", pg(2, 3), 1'b0, K_HIT, {20'h00102, 12'h0});
        expect_lk("R8", pg(9, 3), 1'b0, K_HIT, {20'h00109, 12'h0});
        expect_lk("R8", pg(4, 3), 1'b0, K_MISS, '0);
    endtask

    task automatic t_rr();
        flush();
        lru_en = 1'b0;
        for (int k = 0; k < 8; k++) fill(pg(k, 5), 2'd0, 20'(16'h200 + k));
        expect_lk("R10", pg(0, 5), 1'b0, K_HIT, {20'h00200, 12'h0});
        fill(pg(8, 5), 2'd0, 20'h00208);
        expect_lk("R10", pg(0, 5), 1'b0, K_MISS, '0);
        expect_lk("R10", pg(1, 5), 1'b0, K_HIT, {20'h00201, 12'h0});
        fill(pg(9, 5), 2'd0, 20'h00209);
        expect_lk("R10", pg(1, 5), 1'b0, K_MISS, '0);
        expect_lk("R10", pg(8, 5), 1'b0, K_HIT, {20'h00208, 12'h0});
        expect_lk("R10", pg(9, 5), 1'b0, K_HIT, {20'h00209, 12'h0});
        lru_en = 1'b1;
    endtask

    task automatic t_collide();
        flush();
        drive(1'b1, 32'h0800_7000, 2'd0, 20'h00E01, 1'b1, 32'h0900_7001, 1'b0);
        expect_lk("R11", 32'h0800_7000, 1'b0, K_MISS, '0);
        drive(1'b1, 32'h0800_8000, 2'd0, 20'h00E02, 1'b1, 32'h0900_7001, 1'b0);
        expect_lk("R11", 32'h0800_8000, 1'b0, K_HIT, 32'h00E0_2000);
        drive(1'b1, 32'h0800_9000, 2'd0, 20'h00E03, 1'b0, '0, 1'b1);
        expect_lk("R11", 32'h0800_9000, 1'b0, K_MISS, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        t_small();
        t_large();
        t_badsize();
        t_multi();
        t_inval();
        t_flushall();
        t_lru();
        t_rr();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule